// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Dead-Time Blanking

This block drives two complementary power switches in a push-pull or bridge stage. A free-running ramp counter sets the switching period, and each ramp cycle is given to exactly one of two drive outputs, `drv_a` or `drv_b`, in strict alternation. Each output therefore switches at half the ramp rate and can be on for at most just under half of its own period. If the two outputs are ORed together, they form a single-ended drive with close to full duty at the ramp rate.

Within a cycle, the selected output turns on once a blanking window at the start of the ramp has ended. It turns off when the ramp reaches a duty command, which is captured once per cycle. The blanking window provides the dead time between the two legs.

Several inputs can cut a pulse short:

- A shutdown request turns both legs off at once.
- An over-current flag ends the active pulse for the rest of its cycle.

An external sync pulse restarts the ramp, so several instances can be locked together. The `sync_out` strobe, which is high during blanking, can feed the next instance in the chain.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: With period setting P (P >= 2), the ramp counts 0, 1, ..., P-1 and then restarts at 0. `sync_out` is high exactly while the ramp is in its blanking window: ramp value 0, or ramp value below `blank_cfg`.
- R2: Every ramp restart hands the next cycle to the other leg. The first cycle after reset belongs to `drv_a`.
- R3: `drv_a` and `drv_b` are never high in the same cycle.
- R4: The selected leg is high exactly when all of the following hold: the ramp is outside blanking, the ramp is below the captured duty value, and no shutdown or over-current condition is present. The other leg is low.
- R5: The duty command is captured on the clock edge that restarts the ramp. A change during a cycle has no effect until the next cycle. The captured value is 0 after reset, so the first cycle gives no pulse.
- R6: A duty command at or below the blanking width gives zero on-time. A duty command at or above P gives on-time from the end of blanking through ramp value P-1, which is P minus the blanking width cycles per leg cycle.
- R7: While `shutdown` is high, both legs are low in that same cycle, whatever the other inputs are.
- R8: When `ilim_trip` is high, both legs go low in that same cycle. They stay low for the rest of the current ramp cycle and recover after the next ramp restart.
- R9: `sync_in` high at a clock edge restarts the ramp at 0 on that edge. It also switches the leg and captures the duty command, just as a natural restart does.
- R10: `rst_n` low resets the block asynchronously, with both legs low. After `rst_n` rises, the ramp starts counting on the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | CNT_W | Duty command, as the ramp value at which the pulse ends |
| period_cfg | input | CNT_W | Ramp period in clock cycles |
| blank_cfg | input | CNT_W | Blanking (dead-time) width in clock cycles |
| shutdown | input | 1 | Forces both legs off |
| ilim_trip | input | 1 | Over-current flag that ends the current pulse |
| sync_in | input | 1 | External ramp restart pulse |
| drv_a | output | 1 | Leg A drive |
| drv_b | output | 1 | Leg B drive |
| sync_out | output | 1 | High during blanking, for chaining instances |

## Verification
The bench targets the following corner cases:

- **Mid-cycle duty change.** A design that samples the command continuously would stretch or clip the pulse already running.
- **Over-current flag dropped after one cycle.** A design that does not hold the trip would let the pulse turn back on within the same cycle.
- **Duty at or below the blanking width, and duty above the period.** A wrong comparison boundary shows up as one cycle too many or too few of on-time per leg.
- **Sync pulses that arrive before the natural period ends.** These must restart the ramp and switch legs. A design that ignored them or failed to toggle would drive the same leg twice in a row.
- **Shutdown.** A shutdown that was registered instead of direct would leak one extra cycle of drive.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {LEG_A = 1'b0, LEG_B = 1'b1} leg_e;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] blank_cfg,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             blank
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q >= (period_cfg - ONE));
    wrap   = sync_in || at_end;
    cnt_d  = wrap ? '0 : (cnt_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign blank = (cnt_q == '0) || (cnt_q < blank_cfg);
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  output leg_e leg
);
  leg_e leg_q, leg_d;

  always_comb begin
    leg_d = leg_q;
    if (wrap) leg_d = (leg_q == LEG_A) ? LEG_B : LEG_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) leg_q <= LEG_A;
    else        leg_q <= leg_d;
  end

  assign leg = leg_q;
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             blank,
  input  logic [CNT_W-1:0] duty_cmd,
  input  leg_e             leg,
  input  logic             shutdown,
  input  logic             ilim_trip,
  output logic [NUM_LEGS-1:0] drv
);
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             trip_q, trip_d;
  logic             on_c;

  always_comb begin
    duty_d = wrap ? duty_cmd : duty_q;
    trip_d = wrap ? 1'b0 : (trip_q | ilim_trip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      trip_q <= 1'b0;
    end else begin
      duty_q <= duty_d;
      trip_q <= trip_d;
    end
  end

  assign on_c = !shutdown && !ilim_trip && !trip_q && !blank && (cnt < duty_q);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign drv[g] = on_c && (leg == ((g == 0) ? LEG_A : LEG_B));
  end
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] blank_cfg,
  input  logic             shutdown,
  input  logic             ilim_trip,
  input  logic             sync_in,
  output logic             drv_a,
  output logic             drv_b,
  output logic             sync_out
);
  logic [1:0]          rst_q;
  logic                rst_int_n;
  logic [CNT_W-1:0]    cnt;
  logic                wrap, blank;
  leg_e                leg;
  logic [NUM_LEGS-1:0] drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst_n(rst_int_n), .period_cfg(period_cfg), .blank_cfg(blank_cfg),
    .sync_in(sync_in), .cnt(cnt), .wrap(wrap), .blank(blank)
  );

  pwm_steer u_steer (
    .clk(clk), .rst_n(rst_int_n), .wrap(wrap), .leg(leg)
  );

  pwm_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .wrap(wrap), .cnt(cnt), .blank(blank),
    .duty_cmd(duty_cmd), .leg(leg), .shutdown(shutdown), .ilim_trip(ilim_trip),
    .drv(drv)
  );

  assign drv_a    = drv[0];
  assign drv_b    = drv[1];
  assign sync_out = blank;
endmodule

// File: rtl/pp_pwm_ctrl_chk.sv
module pp_pwm_ctrl_chk
  import pwm_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic drv_a,
  input logic drv_b,
  input logic sync_out,
  input logic shutdown,
  input logic ilim_trip,
  input logic sync_in,
  input logic wrap,
  input leg_e leg
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_a && drv_b));

  assert_blank_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (!drv_a && !drv_b));

  assert_leg_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (leg != $past(leg)));

  assert_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!drv_a && !drv_b));

  assert_trip_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_trip |-> (!drv_a && !drv_b));

  assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip && !wrap) |=> (!drv_a && !drv_b));

  assert_sync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> sync_out);
endmodule

bind pp_pwm_ctrl pp_pwm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .drv_a(drv_a), .drv_b(drv_b), .sync_out(sync_out),
  .shutdown(shutdown), .ilim_trip(ilim_trip), .sync_in(sync_in), .wrap(wrap), .leg(leg)
);

// File: tb/pp_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_bench;
  localparam int W = 8;
  localparam int P = 20;
  localparam int B = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] duty_cmd, period_cfg, blank_cfg;
  logic         shutdown, ilim_trip, sync_in;
  logic         drv_a, drv_b, sync_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pp_pwm_ctrl #(.CNT_W(W)) u_pp_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .period_cfg(period_cfg),
    .blank_cfg(blank_cfg), .shutdown(shutdown), .ilim_trip(ilim_trip),
    .sync_in(sync_in), .drv_a(drv_a), .drv_b(drv_b), .sync_out(sync_out)
  );

  // Reference built from the requirement text (R1, R2, R4, R5, R8, R9, R10)
  logic [1:0]   m_rq;
  logic [W-1:0] m_cnt, m_duty;
  logic         m_sel, m_trip;
  logic         m_wrap, m_blank, m_on, exp_a, exp_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) m_rq <= 2'b00; else m_rq <= {m_rq[0], 1'b1};

  always_comb begin
    m_wrap  = sync_in || (int'(m_cnt) >= int'(period_cfg) - 1);
    m_blank = (m_cnt == 0) || (m_cnt < blank_cfg);
    m_on    = !m_blank && (m_cnt < m_duty) && !m_trip && !shutdown && !ilim_trip;
    exp_a   = m_on && !m_sel;
    exp_b   = m_on && m_sel;
  end

  always_ff @(posedge clk or negedge m_rq[1]) begin
    if (!m_rq[1]) begin
      m_cnt <= '0; m_duty <= '0; m_sel <= 1'b0; m_trip <= 1'b0;
    end else if (m_wrap) begin
      m_cnt <= '0; m_duty <= duty_cmd; m_sel <= ~m_sel; m_trip <= 1'b0;
    end else begin
      m_cnt <= m_cnt + 1'b1; m_trip <= m_trip | ilim_trip;
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run(input int n, input string tag, output int na, output int nb);
    na = 0; nb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check({tag, " drv_a"}, drv_a, exp_a);
      check({tag, " drv_b"}, drv_b, exp_b);
      check({tag, " sync_out R1"}, sync_out, m_blank);
      check("R3 overlap", drv_a & drv_b, 0);
      na += drv_a; nb += drv_b;
    end
  endtask

  task automatic restart();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic t_reset_r10();
    int na, nb;
    rst_n = 1'b0; #20;
    check("R10 reset drv_a", drv_a, 0);
    check("R10 reset drv_b", drv_b, 0);
    check("R10 reset sync_out", sync_out, 1);
    @(negedge clk); rst_n = 1'b1;
    run(2 * P, "R10/R5 first cycles", na, nb);
    check("R5 first cycle no pulse on A", na, 0);
  endtask

  task automatic t_basic_r4();
    int na, nb;
    duty_cmd = 8'd12; restart();
    run(2 * P, "R4 basic", na, nb);
    check("R4 A on-cycles", na, 12 - B);
    check("R4 B on-cycles", nb, 12 - B);
    run(4 * P, "R2 steady", na, nb);
    check("R2 A share", na, 2 * (12 - B));
    check("R2 B share", nb, 2 * (12 - B));
  endtask

  task automatic t_limits_r6();
    int na, nb;
    duty_cmd = 8'd255; restart();
    run(2 * P, "R6 max", na, nb);
    check("R6 max A", na, P - B);
    check("R6 max B", nb, P - B);
    duty_cmd = 8'd3; restart();
    run(2 * P, "R6 zero at blank", na, nb);
    check("R6 zero A+B", na + nb, 0);
    duty_cmd = 8'd1; restart();
    run(2 * P, "R6 zero below blank", na, nb);
    check("R6 low A+B", na + nb, 0);
  endtask

  task automatic t_midchange_r5();
    int na, nb, ma, mb;
    duty_cmd = 8'd12; restart();
    run(5, "R5 pre", na, nb);
    duty_cmd = 8'd18;
    run(P - 5, "R5 mid", ma, mb);
    check("R5 held pulse", na + nb + ma + mb, 12 - B);
    run(P, "R5 next", na, nb);
    check("R5 new pulse", na + nb, 18 - B);
  endtask

  task automatic t_shutdown_r7();
    int na, nb;
    duty_cmd = 8'd15; restart();
    run(4, "R7 pre", na, nb);
    @(negedge clk); shutdown = 1'b1; #1;
    check("R7 immediate A", drv_a, 0);
    check("R7 immediate B", drv_b, 0);
    run(2 * P, "R7 hold", na, nb);
    check("R7 held off", na + nb, 0);
    shutdown = 1'b0;
    run(2 * P, "R7 release", na, nb);
  endtask

  task automatic t_trip_r8();
    int na, nb;
    duty_cmd = 8'd15; restart();
    run(5, "R8 pre", na, nb);
    check("R8 pulse before trip", na + nb, 3);
    @(negedge clk); ilim_trip = 1'b1; #1;
    check("R8 immediate off", drv_a | drv_b, 0);
    @(negedge clk); ilim_trip = 1'b0; #1;
    check("R8 latched off", drv_a | drv_b, 0);
    run(P - 7, "R8 rest", na, nb);
    check("R8 stays off in cycle", na + nb, 0);
    run(P, "R8 recover", na, nb);
    check("R8 next cycle pulse", na + nb, 15 - B);
  endtask

  task automatic t_sync_r9();
    int na, nb;
    period_cfg = 8'd30; duty_cmd = 8'd12;
    for (int k = 0; k < 4; k++) begin
      restart(); #1;
      check("R9 sync_out after sync", sync_out, 1);
      run(18, "R9 synced", na, nb);
      check("R9 one leg per cycle", (na == 0) || (nb == 0), 1);
      check("R9 pulse width", na + nb, 12 - B);
    end
    period_cfg = P;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; duty_cmd = 8'd12; period_cfg = P; blank_cfg = B;
    shutdown = 1'b0; ilim_trip = 1'b0; sync_in = 1'b0;
    t_reset_r10();
    t_basic_r4();
    t_limits_r6();
    t_midchange_r5();
    t_shutdown_r7();
    t_trip_r8();
    t_sync_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule